// File: doc/BRIEF.md
# Two-Level Spiking Winner-Take-All

This block models a bank of integrate-and-fire neuron arrays organised as several feature maps. Each incoming spike event names a feature map and a neuron inside it; the addressed neuron's membrane grows by a programmable synaptic weight. When a membrane reaches the threshold, that neuron fires. Its map's inhibitor then silences every competing neuron. Only the winner keeps a head start, which it gets from a self-excitation preload.

A second level of competition links the maps. When the cross-map mode is on, a firing in any map also inhibits every neuron of every other map, so only the map that leads the race reports. When the mode is off, each map competes on its own and reports its own winners. Every firing leaves the block as an output event that carries the feature index and the neuron address.

Both data interfaces are valid/ready streams. An input event is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` drops for the one cycle in which inhibition is applied. It also stays low whenever the single output slot holds an event that the sink does not take in that cycle. An output event stays on the port without change until `out_ready` takes it. The configuration pins are plain levels and should be held steady while events flow.

Top module: `wta_two_level`

## Requirements
- R1: An input event is accepted only on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low in the cycle that follows an accepted firing spike, and it is low while `out_valid` is high and `out_ready` is low.
- R2: Each accepted spike adds `cfg_weight` to the membrane of neuron `in_addr` (row times 8 plus column) in map `in_feat`. Starting from a membrane of zero, the neuron fires on the spike that brings the sum to `cfg_thresh` or above. Weight 10 and threshold 40 therefore need four spikes.
- R3: A firing sets `out_valid` after the same edge that accepted the spike. `out_feat` and `out_addr` carry the map index and neuron address of the firing neuron.
- R4: Self-excitation applies only to the neuron that fired. Its membrane is loaded with `cfg_thresh >> cfg_hyst_shift`, and a shift value of 0 loads zero. With threshold 40, weight 10 and shift 1, a winner refires after two further spikes.
- R5: In the cycle after a firing, every other membrane in the winner's map is set to zero.
- R6: When `cfg_global_en` is 1, that inhibition also sets to zero every membrane in every other map. When it is 0, the other maps keep their state.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_feat` and `out_addr` stay unchanged.
- R8: After reset, `out_valid` is 0, `in_ready` is 1 and all membranes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_weight | input | MEM_W | Synaptic weight added per spike |
| cfg_thresh | input | MEM_W | Firing threshold (non-zero) |
| cfg_hyst_shift | input | 3 | Self-excitation preload as threshold right-shift, 0 disables |
| cfg_global_en | input | 1 | 1 enables cross-map competition |
| in_valid | input | 1 | Input spike event valid |
| in_ready | output | 1 | Block can take an input event |
| in_feat | input | log2(MAPS) | Target feature map |
| in_addr | input | log2(SIDE*SIDE) | Target neuron, row*SIDE+column |
| out_valid | output | 1 | Winner event valid |
| out_ready | input | 1 | Sink takes the winner event |
| out_feat | output | log2(MAPS) | Winning feature map |
| out_addr | output | log2(SIDE*SIDE) | Winning neuron address |

## Verification
The embedded properties cover the timing that holds on every cycle. Each firing is followed by an inhibition cycle in which no input is taken and no map is touched by a spike. A winner's membrane holds the preload on the cycle after it fires. A stalled output event keeps its contents, and a new winner never overwrites an event that has not been taken. The effects of competition can only be seen across a sequence of spikes, so the bench's scenarios show them. These effects are the spike count a neuron needs, a rival that must restart from zero, a head start after winning, and whether another map survives a firing in each mode.

// File: rtl/wta_pkg.sv
package wta_pkg;
  typedef enum logic {
    SCOPE_LOCAL  = 1'b0,
    SCOPE_GLOBAL = 1'b1
  } inhibit_scope_e;

  function automatic logic [7:0] shift_amount(input logic [2:0] sh);
    return {5'd0, sh};
  endfunction
endpackage

// File: rtl/wta_neuron_map.sv
module wta_neuron_map #(
  parameter int SIDE  = 8,
  parameter int MEM_W = 8,
  localparam int N    = SIDE * SIDE,
  localparam int AW   = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [AW-1:0]    addr,
  input  logic [MEM_W-1:0] weight,
  input  logic [MEM_W-1:0] thresh,
  input  logic [MEM_W-1:0] preload,
  input  logic             clear,
  input  logic             keep,
  input  logic [AW-1:0]    keep_addr,
  output logic             fire
);
  logic [MEM_W-1:0] mem [N];
  logic [MEM_W:0]   sum;

  always_comb begin
    sum  = {1'b0, mem[addr]} + {1'b0, weight};
    fire = hit && (sum >= {1'b0, thresh});
  end

  for (genvar n = 0; n < N; n++) begin : g_neuron
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[n] <= '0;
      else if (hit && addr == AW'(n))
        mem[n] <= fire ? preload : sum[MEM_W-1:0];
      else if (clear && !(keep && keep_addr == AW'(n)))
        mem[n] <= '0;
    end
  end

  // R4: the winner holds its self-excitation preload after firing
  a_r4_winner_preload: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> mem[$past(addr)] == $past(preload));

  // R5: an inhibition cycle never coincides with a spike into the map
  a_r5_no_hit_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !hit);
endmodule

// File: rtl/wta_inhibit_ctrl.sv
module wta_inhibit_ctrl
  import wta_pkg::*;
#(
  parameter int MAPS = 4,
  parameter int AW   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAPS-1:0]  fire_vec,
  input  logic [AW-1:0]    fire_addr,
  input  inhibit_scope_e   scope,
  output logic [MAPS-1:0]  clear_vec,
  output logic [MAPS-1:0]  keep_vec,
  output logic [AW-1:0]    keep_addr,
  output logic             busy
);
  logic [MAPS-1:0] win_q;
  logic            all_q;
  logic [AW-1:0]   addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      win_q  <= '0;
      all_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      busy <= |fire_vec;
      if (|fire_vec) begin
        win_q  <= fire_vec;
        all_q  <= (scope == SCOPE_GLOBAL);
        addr_q <= fire_addr;
      end
    end
  end

  for (genvar m = 0; m < MAPS; m++) begin : g_level2
    assign clear_vec[m] = busy && (all_q || win_q[m]);
    assign keep_vec[m]  = win_q[m];
  end
  assign keep_addr = addr_q;

  // R5: every firing is followed by one inhibition cycle
  a_r5_inhibit_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire_vec) |=> busy);

  // R6: at most one map fires per cycle
  a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_vec));
endmodule

// File: rtl/wta_event_out.sv
module wta_event_out #(
  parameter int FW = 2,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] load_feat,
  input  logic [AW-1:0] load_addr,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [FW-1:0] out_feat,
  output logic [AW-1:0] out_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_feat  <= '0;
      out_addr  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_feat  <= load_feat;
      out_addr  <= load_addr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: a stalled event stays unchanged
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_feat) && $stable(out_addr));

  // R3: a new winner never overwrites an untaken event
  a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!out_valid || out_ready));
endmodule

// File: rtl/wta_two_level.sv
module wta_two_level
  import wta_pkg::*;
#(
  parameter int MAPS  = 4,
  parameter int SIDE  = 8,
  parameter int MEM_W = 8,
  localparam int FW   = $clog2(MAPS),
  localparam int AW   = $clog2(SIDE * SIDE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MEM_W-1:0] cfg_weight,
  input  logic [MEM_W-1:0] cfg_thresh,
  input  logic [2:0]       cfg_hyst_shift,
  input  logic             cfg_global_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FW-1:0]    in_feat,
  input  logic [AW-1:0]    in_addr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [FW-1:0]    out_feat,
  output logic [AW-1:0]    out_addr
);
  logic             accept;
  logic             busy;
  logic [MAPS-1:0]  fire_vec;
  logic [MAPS-1:0]  clear_vec;
  logic [MAPS-1:0]  keep_vec;
  logic [AW-1:0]    keep_addr;
  logic [MEM_W-1:0] preload;

  assign in_ready = !busy && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;
  assign preload  = (cfg_hyst_shift == 3'd0) ? '0
                    : MEM_W'(cfg_thresh >> shift_amount(cfg_hyst_shift));

  for (genvar m = 0; m < MAPS; m++) begin : g_map
    wta_neuron_map #(.SIDE(SIDE), .MEM_W(MEM_W)) i_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (accept && in_feat == FW'(m)),
      .addr      (in_addr),
      .weight    (cfg_weight),
      .thresh    (cfg_thresh),
      .preload   (preload),
      .clear     (clear_vec[m]),
      .keep      (keep_vec[m]),
      .keep_addr (keep_addr),
      .fire      (fire_vec[m])
    );
  end

  wta_inhibit_ctrl #(.MAPS(MAPS), .AW(AW)) i_inhibit (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_vec  (fire_vec),
    .fire_addr (in_addr),
    .scope     (inhibit_scope_e'(cfg_global_en)),
    .clear_vec (clear_vec),
    .keep_vec  (keep_vec),
    .keep_addr (keep_addr),
    .busy      (busy)
  );

  wta_event_out #(.FW(FW), .AW(AW)) i_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (|fire_vec),
    .load_feat (in_feat),
    .load_addr (in_addr),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_feat  (out_feat),
    .out_addr  (out_addr)
  );

  // R1: no event is taken during the inhibition cycle
  a_r1_stall_on_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  // R1: back-pressure on the output stalls the input
  a_r1_stall_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/test_wta_two_level.sv
module test_wta_two_level;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cfg_weight, cfg_thresh;
  logic [2:0] cfg_hyst_shift;
  logic       cfg_global_en;
  logic       in_valid, in_ready, out_valid, out_ready;
  logic [1:0] in_feat, out_feat;
  logic [5:0] in_addr, out_addr;

  int checks = 0, errors = 0, ev_cnt = 0;
  logic [1:0] ev_feat;
  logic [5:0] ev_addr;
  logic       ready_after;
  bit         done = 0;

  always #10 clk = ~clk;

  wta_two_level i_wta_two_level (
    .clk(clk), .rst_n(rst_n), .cfg_weight(cfg_weight), .cfg_thresh(cfg_thresh),
    .cfg_hyst_shift(cfg_hyst_shift), .cfg_global_en(cfg_global_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_feat(in_feat), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_feat(out_feat), .out_addr(out_addr)
  );

  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      ev_cnt  = ev_cnt + 1;
      ev_feat = out_feat;
      ev_addr = out_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] sh, input logic glob);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_feat = '0; in_addr = '0; out_ready = 1'b1;
    cfg_weight = 8'd10; cfg_thresh = 8'd40; cfg_hyst_shift = sh; cfg_global_en = glob;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [1:0] f, input logic [5:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_feat = f; in_addr = a;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    ready_after = in_ready;
    @(negedge clk);
  endtask

  task automatic send_n(input logic [1:0] f, input logic [5:0] a, input int n);
    for (int i = 0; i < n; i++) send(f, a);
  endtask

  task automatic t_reset;
    do_reset(3'd0, 1'b0);
    chk(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R8 in_ready after reset", int'(in_ready), 1);
    // R8: membranes start at zero, so four spikes are needed
    begin
      int base = ev_cnt;
      send_n(2'd1, 6'd3, 3);
      chk(ev_cnt == base, "R8 zero membrane", ev_cnt - base, 0);
      send(2'd1, 6'd3);
      chk(ev_cnt == base + 1, "R8 zero membrane fire", ev_cnt - base, 1);
    end
  endtask

  task automatic t_accumulate;
    int base;
    do_reset(3'd0, 1'b0);
    base = ev_cnt;
    send_n(2'd0, 6'd5, 3);
    chk(ev_cnt == base, "R2 below threshold", ev_cnt - base, 0);
    chk(ready_after == 1'b1, "R1 ready after non-firing spike", int'(ready_after), 1);
    send(2'd0, 6'd5);
    chk(ev_cnt == base + 1, "R2 fires on fourth spike", ev_cnt - base, 1);
    chk(ready_after == 1'b0, "R1 stall in inhibition cycle", int'(ready_after), 0);
    chk(ev_feat == 2'd0, "R3 event feature", int'(ev_feat), 0);
    chk(ev_addr == 6'd5, "R3 event address", int'(ev_addr), 5);
  endtask

  task automatic t_hysteresis;
    int base;
    do_reset(3'd1, 1'b0);
    base = ev_cnt;
    send_n(2'd1, 6'd9, 4);
    chk(ev_cnt == base + 1, "R4 first win", ev_cnt - base, 1);
    send(2'd1, 6'd9);
    chk(ev_cnt == base + 1, "R4 preload below threshold", ev_cnt - base, 1);
    send(2'd1, 6'd9);
    chk(ev_cnt == base + 2, "R4 refire after two spikes", ev_cnt - base, 2);
    chk(ev_addr == 6'd9 && ev_feat == 2'd1, "R4 refire address", int'(ev_addr), 9);
  endtask

  task automatic t_map_inhibit;
    int base;
    do_reset(3'd0, 1'b0);
    base = ev_cnt;
    send_n(2'd2, 6'd1, 3);
    send_n(2'd2, 6'd2, 4);
    chk(ev_cnt == base + 1 && ev_addr == 6'd2, "R5 rival wins", int'(ev_addr), 2);
    send_n(2'd2, 6'd1, 3);
    chk(ev_cnt == base + 1, "R5 loser restarted from zero", ev_cnt - base, 1);
    send(2'd2, 6'd1);
    chk(ev_cnt == base + 2 && ev_addr == 6'd1, "R5 loser fires after four", int'(ev_addr), 1);
  endtask

  task automatic t_global_off;
    int base;
    do_reset(3'd0, 1'b0);
    base = ev_cnt;
    send_n(2'd3, 6'd0, 3);
    send_n(2'd0, 6'd7, 4);
    chk(ev_cnt == base + 1, "R6 local winner", ev_cnt - base, 1);
    send(2'd3, 6'd0);
    chk(ev_cnt == base + 2, "R6 other map kept state", ev_cnt - base, 2);
    chk(ev_feat == 2'd3 && ev_addr == 6'd0, "R6 other map event", int'(ev_feat), 3);
  endtask

  task automatic t_global_on;
    int base;
    do_reset(3'd0, 1'b1);
    base = ev_cnt;
    send_n(2'd3, 6'd0, 3);
    send_n(2'd0, 6'd8, 4);
    chk(ev_cnt == base + 1 && ev_feat == 2'd0, "R6 global winner", int'(ev_feat), 0);
    send(2'd3, 6'd0);
    chk(ev_cnt == base + 1, "R6 other map cleared", ev_cnt - base, 1);
    send_n(2'd3, 6'd0, 3);
    chk(ev_cnt == base + 2 && ev_feat == 2'd3, "R6 other map refires after four", ev_cnt - base, 2);
  endtask

  task automatic t_backpressure;
    int base;
    do_reset(3'd0, 1'b0);
    out_ready = 1'b0;
    base = ev_cnt;
    send_n(2'd2, 6'd33, 4);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R7 held valid", int'(out_valid), 1);
      chk(out_feat == 2'd2 && out_addr == 6'd33, "R7 held address", int'(out_addr), 33);
      chk(in_ready == 1'b0, "R1 stalled by output", int'(in_ready), 0);
    end
    chk(ev_cnt == base, "R7 nothing taken", ev_cnt - base, 0);
    out_ready = 1'b1;
    @(negedge clk);
    chk(ev_cnt == base + 1, "R7 taken after release", ev_cnt - base, 1);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 ready after drain", int'(in_ready), 1);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_accumulate();
    t_hysteresis();
    t_map_inhibit();
    t_global_off();
    t_global_on();
    t_backpressure();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule